// File: doc/BRIEF.md
# SPI Flash Auto-Increment Program Sequencer

This block sits behind a host bus front end and converts single-byte memory write requests into auto-address-increment program transfers on an SPI flash master port. It remembers, from one host write to the next, whether the coming write opens a new auto-increment run or continues one already under way. An opening write is sent as the fixed program opcode 0xAF, then three address bytes, then the data byte. A continuing write is sent as the opcode and the data byte only.

While a frame is being shifted out, the block reports a long-wait status to the front end. When the frame ends it reports ready for one cycle and turnaround for one cycle, then returns to idle. Three events put the block back into opening-write mode: the enable input going low, a sequencer reset pulse, or notice that another flash command (a read or a pass-through command) has run. The SPI clock rate is set from the system clock by a divider input.

Top module: `aai_prog_seq`

## Requirements
- R1: A write request is accepted only while the block is idle, `aai_en`=1, `dummy_en`=0, `wait_en_a`=1 and `wait_en_b`=1. A request that fails any of these starts no frame: `spi_cs_n` stays 1, `busy` stays 0 and `host_status` stays 00.
- R2: An accepted write in opening-write mode (`next_is_first`=1) sends 40 bits: 0xAF, then `wr_addr[23:16]`, `wr_addr[15:8]`, `wr_addr[7:0]`, then `wr_data`. Address and data are captured in the cycle of acceptance.
- R3: An accepted write while `next_is_first`=0 sends 16 bits: 0xAF, then `wr_data`. No address is sent. Every accepted write clears `next_is_first`.
- R4: Each byte goes out most-significant bit first. The serial line uses SPI mode 0: `spi_sck` idles low and the flash samples `spi_mosi` on the rising edge.
- R5: `spi_cs_n` is low for the whole of a frame. `spi_sck` is low whenever `spi_cs_n` is high. Between two frames `spi_cs_n` stays high for at least two clock cycles.
- R6: `host_status` encodes 00 idle, 01 long wait, 10 ready and 11 turnaround. It reads 01 from the cycle after acceptance until the last bit ends, then 10 for one cycle, then 11 for one cycle, then 00. `busy` is 1 whenever `host_status` is not 00.
- R7: `aai_en` low for any cycle sets `next_is_first` to 1.
- R8: A one-cycle pulse on `seq_reset` sets `next_is_first` to 1.
- R9: A one-cycle pulse on `other_cmd` sets `next_is_first` to 1.
- R10: A write request that arrives while `busy`=1 is ignored and the frame in progress is not changed. `wr_reject` is 1 in the following cycle.
- R11: Each SPI clock half-period lasts `clk_div`+1 system clocks. The long-wait phase of a frame of N bits therefore lasts 2·N·(`clk_div`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aai_en | input | 1 | Auto-increment program enable |
| dummy_en | input | 1 | Dummy-cycle option; blocks acceptance when 1 |
| wait_en_a | input | 1 | First wait-enable control |
| wait_en_b | input | 1 | Second wait-enable control |
| seq_reset | input | 1 | Sequencer reset pulse, returns to opening-write mode |
| other_cmd | input | 1 | Another flash command has run |
| wr_req | input | 1 | Host byte write request, one cycle |
| wr_addr | input | 24 | Flash byte address |
| wr_data | input | 8 | Write data byte |
| clk_div | input | 8 | SPI half-period minus one, in system clocks |
| wr_reject | output | 1 | A request arrived while busy (one cycle late) |
| busy | output | 1 | Frame or status sequence in progress |
| host_status | output | 2 | 00 idle, 01 long wait, 10 ready, 11 turnaround |
| next_is_first | output | 1 | Next accepted write opens a run |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |

## Verification
Opening and continuing writes are issued with random addresses, data bytes and divider values. The bit stream gathered on rising SPI clock edges must match the 40-bit or 16-bit expected frame, and the long-wait length must match the divider formula. The frame length shows whether opening-write mode was entered or left. Each return-to-opening event (enable drop, sequencer reset, other command) is placed between writes, so a missed event shows up as a short frame where a long one was due. Blocked requests, one for each failing accept condition, must leave the chip select and status at rest. A request injected in the middle of a frame must raise the reject flag without changing the bits on the wire.

// File: rtl/aai_pkg.sv
package aai_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_READY = 2'b10,
        ST_TURN  = 2'b11
    } aai_state_e;

    localparam logic [7:0] AAI_OPCODE = 8'hAF;
endpackage

// File: rtl/aai_sck_divider.sv
module aai_sck_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/aai_bit_shifter.sv
module aai_bit_shifter #(
    parameter int FRAME_W = 40,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   load_bits,
    input  logic               tick,
    output logic               active,
    output logic               sck,
    output logic               mosi,
    output logic               done
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   left;
        logic               sck;
        logic               active;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        done = 1'b0;
        if (load) begin
            sh_d.sr     = load_frame;
            sh_d.left   = load_bits;
            sh_d.sck    = 1'b0;
            sh_d.active = 1'b1;
        end else if (sh_q.active && tick) begin
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
            end else begin
                sh_d.sck  = 1'b0;
                sh_d.sr   = {sh_q.sr[FRAME_W-2:0], 1'b0};
                sh_d.left = sh_q.left - 1'b1;
                if (sh_q.left == CNT_W'(1)) begin
                    sh_d.active = 1'b0;
                    done        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign active = sh_q.active;
    assign sck    = sh_q.sck;
    assign mosi   = sh_q.sr[FRAME_W-1];

    // R11
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(sck));

    // R4
    mosi_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && $rose(sck)) |-> $stable(mosi));
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
    import aai_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aai_en,
    input  logic              dummy_en,
    input  logic              wait_en_a,
    input  logic              wait_en_b,
    input  logic              seq_reset,
    input  logic              other_cmd,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              wr_reject,
    output logic              busy,
    output logic [1:0]        host_status,
    output logic              next_is_first,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi
);
    localparam int OP_W     = $bits(AAI_OPCODE);
    localparam int FRAME_W  = OP_W + ADDR_W + DATA_W;
    localparam int SHORT_W  = OP_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        aai_state_e state;
        logic       first;
        logic       reject;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               accept, back_to_first;
    logic               tick, sh_active, sh_done;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_bits;

    always_comb begin
        accept = (ctl_q.state == ST_IDLE) && wr_req && aai_en && !dummy_en
                 && wait_en_a && wait_en_b;
        back_to_first = !aai_en || seq_reset || other_cmd;

        if (ctl_q.first) begin
            frame      = {AAI_OPCODE, wr_addr, wr_data};
            frame_bits = CNT_W'(FRAME_W);
        end else begin
            frame      = {AAI_OPCODE, wr_data, {ADDR_W{1'b0}}};
            frame_bits = CNT_W'(SHORT_W);
        end

        ctl_d        = ctl_q;
        ctl_d.reject = wr_req && (ctl_q.state != ST_IDLE);
        unique case (ctl_q.state)
            ST_IDLE: if (accept) begin
                ctl_d.state = ST_SHIFT;
                ctl_d.first = 1'b0;
            end
            ST_SHIFT: if (sh_done) ctl_d.state = ST_READY;
            ST_READY: ctl_d.state = ST_TURN;
            default:  ctl_d.state = ST_IDLE;
        endcase
        if (back_to_first) ctl_d.first = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.first  <= 1'b1;
            ctl_q.reject <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    aai_sck_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .div   (clk_div),
        .tick  (tick)
    );

    aai_bit_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_frame (frame),
        .load_bits  (frame_bits),
        .tick       (tick),
        .active     (sh_active),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .done       (sh_done)
    );

    assign host_status   = ctl_q.state;
    assign busy          = (ctl_q.state != ST_IDLE);
    assign next_is_first = ctl_q.first;
    assign wr_reject     = ctl_q.reject;
    assign spi_cs_n      = (ctl_q.state != ST_SHIFT);

    // R5
    cs_sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R5
    shifter_cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> !spi_cs_n);

    // R6
    ready_then_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status == 2'b10) |=> (host_status == 2'b11));

    // R6
    turn_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status == 2'b11) |=> (host_status == 2'b00));

    // R10
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && busy) |=> wr_reject);

    // R9
    other_cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_cmd |=> next_is_first);

    // R1
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req && dummy_en) |=> !busy);
endmodule

// File: tb/aai_prog_seq_tb.sv
module aai_prog_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aai_en = 1'b0, dummy_en = 1'b0, wait_en_a = 1'b1, wait_en_b = 1'b1;
    logic        seq_reset = 1'b0, other_cmd = 1'b0, wr_req = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [7:0]  wr_data = '0, clk_div = '0;
    logic        wr_reject, busy, next_is_first, spi_cs_n, spi_sck, spi_mosi;
    logic [1:0]  host_status;

    int   checks = 0, errors = 0;
    bit   exp_first = 1'b1;
    logic [39:0] cap = '0;
    int   nb = 0, mode_err = 0;

    always #2 clk = ~clk;

    aai_prog_seq u_dut (
        .clk(clk), .rst_n(rst_n), .aai_en(aai_en), .dummy_en(dummy_en),
        .wait_en_a(wait_en_a), .wait_en_b(wait_en_b), .seq_reset(seq_reset),
        .other_cmd(other_cmd), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_div(clk_div), .wr_reject(wr_reject),
        .busy(busy), .host_status(host_status), .next_is_first(next_is_first),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    always @(posedge spi_sck) begin
        cap = {cap[38:0], spi_mosi};
        nb++;
        if (spi_cs_n) mode_err++;
    end

    always @(spi_cs_n) if (spi_sck) mode_err++;

    function automatic logic [39:0] exp_frame(bit first, logic [23:0] a, logic [7:0] d);
        if (first) return {8'hAF, a, d};
        return {24'h0, 8'hAF, d};
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(logic [23:0] a, logic [7:0] d, int dv, bit try_rej);
        int nbits, lw, k;
        logic [39:0] ef;
        nbits = exp_first ? 40 : 16;
        ef = exp_frame(exp_first, a, d);
        @(negedge clk);
        check("R3", "mode before write", next_is_first, exp_first);
        cap = '0; nb = 0; mode_err = 0;
        clk_div = 8'(dv); wr_addr = a; wr_data = d; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        lw = 0; k = 0;
        while (host_status == 2'b01) begin
            lw++; k++;
            if (spi_cs_n) mode_err++;
            if (try_rej && k == 3) begin
                wr_addr = ~a; wr_data = ~d; wr_req = 1'b1;
            end
            @(negedge clk);
            if (try_rej && k == 3) begin
                wr_req = 1'b0;
                check("R10", "reject flag", wr_reject, 1);
            end
        end
        check("R11", "long wait length", lw, 2 * nbits * (dv + 1));
        check("R6", "ready status", host_status, 2);
        check("R5", "cs high at ready", spi_cs_n, 1);
        @(negedge clk);
        check("R6", "turnaround status", host_status, 3);
        check("R6", "busy in turnaround", busy, 1);
        @(negedge clk);
        check("R6", "idle status", host_status, 0);
        check(exp_first ? "R2" : "R3", "bit count", nb, nbits);
        check(exp_first ? "R2" : "R3", "frame bits", cap, ef);
        check("R4", "mode 0 framing", mode_err, 0);
        exp_first = 1'b0;
        check("R3", "mode after write", next_is_first, 0);
    endtask

    task automatic blocked_write(int kind);
        @(negedge clk);
        cap = '0; nb = 0;
        case (kind)
            0: dummy_en = 1'b1;
            1: wait_en_a = 1'b0;
            2: wait_en_b = 1'b0;
            default: begin aai_en = 1'b0; exp_first = 1'b1; end
        endcase
        wr_req = 1'b1; wr_addr = 24'h123456; wr_data = 8'h5A;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "blocked busy", busy, 0);
        check("R1", "blocked cs", spi_cs_n, 1);
        check("R1", "blocked status", host_status, 0);
        check("R1", "blocked no clocks", nb, 0);
        dummy_en = 1'b0; wait_en_a = 1'b1; wait_en_b = 1'b1; aai_en = 1'b1;
        @(negedge clk);
        check("R1", "mode after blocked", next_is_first, exp_first);
    endtask

    task automatic back_to_first(int kind);
        @(negedge clk);
        case (kind)
            0: aai_en = 1'b0;
            1: seq_reset = 1'b1;
            default: other_cmd = 1'b1;
        endcase
        @(negedge clk);
        aai_en = 1'b1; seq_reset = 1'b0; other_cmd = 1'b0;
        exp_first = 1'b1;
        case (kind)
            0: check("R7", "enable drop", next_is_first, 1);
            1: check("R8", "sequencer reset", next_is_first, 1);
            default: check("R9", "other command", next_is_first, 1);
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed, ev;
        seed = 32'h1F00AA17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R6", "reset status", host_status, 0);
        check("R5", "reset cs", spi_cs_n, 1);
        check("R4", "reset sck", spi_sck, 0);
        check("R2", "reset mode", next_is_first, 1);
        rst_n = 1'b1;
        aai_en = 1'b1;
        do_write(24'h064A70, 8'h01, 0, 1'b0);
        do_write(24'h064A71, 8'h80, 1, 1'b0);
        do_write(24'h000000, 8'hFF, 2, 1'b1);
        back_to_first(1);
        do_write(24'hFFFFFF, 8'h00, 0, 1'b1);
        for (int i = 0; i < 4; i++) blocked_write(i);
        back_to_first(2);
        do_write(24'h800001, 8'hC3, 3, 1'b0);
        back_to_first(0);
        do_write(24'hA5A5A5, 8'h3C, 0, 1'b0);
        for (int i = 0; i < 24; i++) begin
            ev = int'($urandom_range(0, 5));
            if (ev < 3) back_to_first(ev);
            else if (ev == 3) blocked_write(int'($urandom_range(0, 3)));
            do_write(24'($urandom), 8'($urandom), int'($urandom_range(0, 3)),
                     bit'($urandom_range(0, 1)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule